// File: doc/BRIEF.md
# Cartridge DMA Control Register Block

This block is the software-facing front of a cartridge-bus DMA channel. It holds a RAM address, a cartridge address, two transfer-length registers and a status word. All of them sit behind a 32-bit word-wide register bus with per-byte write lanes. Writing one of the length registers launches a transfer. The register that was written fixes the direction: the write-length register moves data from the cartridge into RAM, and the read-length register moves it the other way.

The block moves no data. It gives an external transfer engine a one-cycle start pulse, with the RAM address, the cartridge address, the byte count and the direction held steady beside it. When the engine returns a done pulse, the block drops its busy flag, latches an interrupt flag and raises its interrupt line.

While a transfer is in flight, writes to the address and length registers are rejected and latch an error flag. Writes to the status word stay available, so software can abort the channel or acknowledge the interrupt.

Top module: `cdma_regs`

## Requirements
- R1: After reset, the RAM address, cartridge address and status words read 0, both length registers read 0x7F, and the interrupt line is low.
- R2: An accepted write to index 0 to 3 stores (old AND NOT lanemask) OR wdata. Here lanemask sets bits [8i+7:8i] for every bus_be[i] that is 1. The whole data word is ORed in, whatever the lanes.
- R3: The RAM address register (index 0) keeps only bits [23:1], so the other bits read 0. The cartridge address register (index 1) always reads with bit 0 clear.
- R4: An accepted write to the write-length register (index 3) pulses xfer_start for exactly one cycle, the cycle after the write. In that cycle xfer_to_ram is 1, xfer_len is the merged value's bits [23:0] plus 1, and the busy bit is set.
- R5: An accepted write to the read-length register (index 2) starts a transfer the same way, with xfer_to_ram 0.
- R6: While busy, a write to index 0 to 3 leaves the register unchanged, starts nothing and sets the error bit.
- R7: If the RAM address register reads 0xFFFFFE (every kept bit set) when a length register is written, no start pulse is made. Busy stays clear, and the interrupt flag and the irq line are set in the next cycle. The length register still takes the written value.
- R8: A done pulse while busy clears busy, sets the interrupt flag and irq, and makes the length register that launched the transfer read 0x7F.
- R9: A status write (index 4) with data bit 0 set clears busy and error. With data bit 1 set it clears the interrupt flag and irq. A status write never sets the error bit.
- R10: Status reads return busy in bit 0, I/O-busy (equal to busy) in bit 1, error in bit 2 and the interrupt flag in bit 3, with all other bits 0. Indices 5 to 7 read 0.
- R11: A done pulse while not busy changes no flag and no register.
- R12: When a done pulse and a clear-interrupt status write arrive in the same cycle, the interrupt flag and irq end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte address bits [4:2] (word index) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lanes cleared before the OR |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| xfer_start | output | 1 | One-cycle transfer launch pulse |
| xfer_to_ram | output | 1 | 1 = cartridge to RAM, 0 = RAM to cartridge |
| xfer_ram_addr | output | 24 | RAM start address |
| xfer_cart_addr | output | 32 | Cartridge start address |
| xfer_len | output | 25 | Byte count of the transfer |
| xfer_done | input | 1 | Completion pulse from the engine |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets the lane-merge rule, including an all-lanes-off write. A design that masked the data by lane would lose the ORed bits that should still land.

It writes while busy. A design that let such writes through would corrupt the addresses of a transfer in flight, or start a second one.

It stages the all-ones RAM address shortcut. A wrong design would pulse xfer_start or stay busy forever.

It collides a done pulse with a clear-interrupt write, and sends a stray done while idle. A wrong priority would lose the interrupt in the first case, and a missing busy qualifier would fire a false interrupt in the second.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_RAM  = 3'd0,
        IDX_CART = 3'd1,
        IDX_RLEN = 3'd2,
        IDX_WLEN = 3'd3,
        IDX_STAT = 3'd4
    } reg_idx_e;

    // status read bit positions
    localparam int ST_BUSY   = 0;
    localparam int ST_IOBUSY = 1;
    localparam int ST_ERR    = 2;
    localparam int ST_INTR   = 3;

    // status write command bit positions
    localparam int CMD_RESET  = 0;
    localparam int CMD_CLRINT = 1;
    localparam int CMD_W      = 2;

endpackage

// File: rtl/cdma_lane_mask.sv
module cdma_lane_mask #(
    parameter int DW = 32,
    localparam int BE_W = DW / 8
) (
    input  logic [BE_W-1:0] be,
    output logic [DW-1:0]   mask
);
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign mask[g*8 +: 8] = {8{be[g]}};
    end
endmodule

// File: rtl/cdma_regfile.sv
module cdma_regfile
    import cdma_pkg::*;
#(
    parameter int             DW      = 32,
    parameter int             RAM_AW  = 24,
    parameter logic [DW-1:0]  LEN_RST = 32'h7F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DW-1:0]        wdata,
    input  logic [DW-1:0]        wmask,
    input  logic                 fin_en,
    input  logic                 fin_to_ram,
    output logic [DW-1:0]        merged,
    output logic [DW-1:0]        ram_q,
    output logic [DW-1:0]        cart_q,
    output logic [DW-1:0]        rlen_q,
    output logic [DW-1:0]        wlen_q
);
    localparam logic [DW-1:0] RAM_KEEP =
        {{(DW-RAM_AW){1'b0}}, {(RAM_AW-1){1'b1}}, 1'b0};
    localparam logic [DW-1:0] CART_KEEP = {{(DW-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [DW-1:0] ram;
        logic [DW-1:0] cart;
        logic [DW-1:0] rlen;
        logic [DW-1:0] wlen;
    } regs_t;

    regs_t st_d, st_q;
    logic [DW-1:0] cur;

    always_comb begin
        case (wr_idx)
            IDX_RAM:  cur = st_q.ram;
            IDX_CART: cur = st_q.cart;
            IDX_RLEN: cur = st_q.rlen;
            default:  cur = st_q.wlen;
        endcase
        merged = (cur & ~wmask) | wdata;

        st_d = st_q;
        if (wr_en) begin
            case (wr_idx)
                IDX_RAM:  st_d.ram  = merged & RAM_KEEP;
                IDX_CART: st_d.cart = merged & CART_KEEP;
                IDX_RLEN: st_d.rlen = merged;
                IDX_WLEN: st_d.wlen = merged;
                default:  ;
            endcase
        end
        if (fin_en) begin
            if (fin_to_ram) st_d.wlen = LEN_RST;
            else            st_d.rlen = LEN_RST;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ram  <= '0;
            st_q.cart <= '0;
            st_q.rlen <= LEN_RST;
            st_q.wlen <= LEN_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_q  = st_q.ram;
    assign cart_q = st_q.cart;
    assign rlen_q = st_q.rlen;
    assign wlen_q = st_q.wlen;
endmodule

// File: rtl/cdma_ctrl.sv
module cdma_ctrl
    import cdma_pkg::*;
#(
    parameter int DW     = 32,
    parameter int RAM_AW = 24,
    parameter int LEN_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [IDX_W-1:0]   bus_idx,
    input  logic [CMD_W-1:0]   cmd,
    input  logic [LEN_W-1:0]   merged_len,
    input  logic [DW-1:0]      ram_q,
    input  logic               xfer_done,
    output logic               reg_wr_en,
    output logic               fin_en,
    output logic               fin_to_ram,
    output logic               busy_q,
    output logic               err_q,
    output logic               intr_q,
    output logic               start_q,
    output logic               to_ram_q,
    output logic [LEN_W:0]     len_q
);
    localparam logic [DW-1:0] RAM_FULL =
        {{(DW-RAM_AW){1'b0}}, {(RAM_AW-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic           busy;
        logic           err;
        logic           intr;
        logic           start;
        logic           to_ram;
        logic [LEN_W:0] len;
    } ctl_t;

    ctl_t st_d, st_q;
    logic mapped, is_stat, is_len, drop;

    always_comb begin
        mapped    = bus_idx <= IDX_STAT;
        is_stat   = bus_idx == IDX_STAT;
        is_len    = (bus_idx == IDX_RLEN) || (bus_idx == IDX_WLEN);
        reg_wr_en = bus_wr && mapped && !is_stat && !st_q.busy;
        drop      = bus_wr && mapped && !is_stat && st_q.busy;
        fin_en    = st_q.busy && xfer_done;

        st_d       = st_q;
        st_d.start = 1'b0;
        if (drop) st_d.err = 1'b1;
        if (bus_wr && is_stat) begin
            if (cmd[CMD_RESET]) begin
                st_d.busy = 1'b0;
                st_d.err  = 1'b0;
            end
            if (cmd[CMD_CLRINT]) st_d.intr = 1'b0;
        end
        if (fin_en) begin
            st_d.busy = 1'b0;
            st_d.intr = 1'b1;
        end
        if (reg_wr_en && is_len) begin
            if (ram_q == RAM_FULL) begin
                st_d.intr = 1'b1;
            end else begin
                st_d.busy   = 1'b1;
                st_d.start  = 1'b1;
                st_d.to_ram = bus_idx == IDX_WLEN;
                st_d.len    = {1'b0, merged_len} + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fin_to_ram = st_q.to_ram;
    assign busy_q     = st_q.busy;
    assign err_q      = st_q.err;
    assign intr_q     = st_q.intr;
    assign start_q    = st_q.start;
    assign to_ram_q   = st_q.to_ram;
    assign len_q      = st_q.len;
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
    import cdma_pkg::*;
#(
    parameter int             DW      = 32,
    parameter int             RAM_AW  = 24,
    parameter int             LEN_W   = 24,
    parameter logic [DW-1:0]  LEN_RST = 32'h7F,
    localparam int            BE_W    = DW / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [IDX_W+1:2]     bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic [BE_W-1:0]      bus_be,
    output logic [DW-1:0]        bus_rdata,
    output logic                 xfer_start,
    output logic                 xfer_to_ram,
    output logic [RAM_AW-1:0]    xfer_ram_addr,
    output logic [DW-1:0]        xfer_cart_addr,
    output logic [LEN_W:0]       xfer_len,
    input  logic                 xfer_done,
    output logic                 irq
);
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    wmask, merged, ram_w, cart_w, rlen_w, wlen_w;
    logic             reg_wr_en, fin_en, fin_to_ram;
    logic             busy_w, err_w, intr_w;

    assign idx = bus_addr;

    cdma_lane_mask #(.DW(DW)) u_mask (
        .be   (bus_be),
        .mask (wmask)
    );

    cdma_regfile #(.DW(DW), .RAM_AW(RAM_AW), .LEN_RST(LEN_RST)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_idx     (idx),
        .wdata      (bus_wdata),
        .wmask      (wmask),
        .fin_en     (fin_en),
        .fin_to_ram (fin_to_ram),
        .merged     (merged),
        .ram_q      (ram_w),
        .cart_q     (cart_w),
        .rlen_q     (rlen_w),
        .wlen_q     (wlen_w)
    );

    cdma_ctrl #(.DW(DW), .RAM_AW(RAM_AW), .LEN_W(LEN_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_idx    (idx),
        .cmd        (bus_wdata[CMD_W-1:0]),
        .merged_len (merged[LEN_W-1:0]),
        .ram_q      (ram_w),
        .xfer_done  (xfer_done),
        .reg_wr_en  (reg_wr_en),
        .fin_en     (fin_en),
        .fin_to_ram (fin_to_ram),
        .busy_q     (busy_w),
        .err_q      (err_w),
        .intr_q     (intr_w),
        .start_q    (xfer_start),
        .to_ram_q   (xfer_to_ram),
        .len_q      (xfer_len)
    );

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_RAM:  bus_rdata = ram_w;
            IDX_CART: bus_rdata = cart_w;
            IDX_RLEN: bus_rdata = rlen_w;
            IDX_WLEN: bus_rdata = wlen_w;
            IDX_STAT: begin
                bus_rdata[ST_BUSY]   = busy_w;
                bus_rdata[ST_IOBUSY] = busy_w;
                bus_rdata[ST_ERR]    = err_w;
                bus_rdata[ST_INTR]   = intr_w;
            end
            default: ;
        endcase
    end

    assign xfer_ram_addr  = ram_w[RAM_AW-1:0];
    assign xfer_cart_addr = cart_w;
    assign irq            = intr_w;
endmodule

// File: rtl/cdma_regs_chk.sv
module cdma_regs_chk #(
    parameter int DW     = 32,
    parameter int RAM_AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [2:0]    idx,
    input logic [DW-1:0] bus_wdata,
    input logic          xfer_done,
    input logic          xfer_start,
    input logic          irq,
    input logic          busy,
    input logic          err,
    input logic [DW-1:0] ram_q
);
    localparam logic [DW-1:0] FULL =
        {{(DW-RAM_AW){1'b0}}, {(RAM_AW-1){1'b1}}, 1'b0};

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> busy);

    assert_drop_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && busy && idx < 3'd4) |=> (err && !xfer_start));

    assert_fast_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && (idx == 3'd2 || idx == 3'd3) && ram_q == FULL)
        |=> (irq && !busy && !xfer_start));

    assert_done_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done) |=> (irq && !busy));

    assert_clear_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == 3'd4 && bus_wdata[1] && !(busy && xfer_done)) |=> !irq);

    assert_stat_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == 3'd4 && !err) |=> !err);

    assert_idle_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && xfer_done && !bus_wr) |=> (irq == $past(irq)));
endmodule

bind cdma_regs cdma_regs_chk #(.DW(DW), .RAM_AW(RAM_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .idx        (idx),
    .bus_wdata  (bus_wdata),
    .xfer_done  (xfer_done),
    .xfer_start (xfer_start),
    .irq        (irq),
    .busy       (busy_w),
    .err        (err_w),
    .ram_q      (ram_w)
);

// File: tb/cdma_regs_test.sv
module cdma_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        xfer_start, xfer_to_ram, irq;
    logic        xfer_done = 1'b0;
    logic [23:0] xfer_ram_addr;
    logic [31:0] xfer_cart_addr;
    logic [24:0] xfer_len;

    always #10 clk = ~clk;

    cdma_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .xfer_start(xfer_start), .xfer_to_ram(xfer_to_ram),
        .xfer_ram_addr(xfer_ram_addr), .xfer_cart_addr(xfer_cart_addr),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .irq(irq)
    );

    // kinds: 0 rdata, 1 irq, 2 xfer_start, 3 xfer_len, 4 xfer_to_ram, 5 xfer_ram_addr
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_err = 0;
    int    cycles = 0;

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = {31'd0, irq};
                2: act = {31'd0, xfer_start};
                3: act = {7'd0, xfer_len};
                4: act = {31'd0, xfer_to_ram};
                default: act = {8'd0, xfer_ram_addr};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [2:0] idx, logic [31:0] d, logic [3:0] be);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = idx; bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic done_pulse();
        @(posedge clk); #1;
        xfer_done = 1'b1;
        @(posedge clk); #1;
        xfer_done = 1'b0;
    endtask

    task automatic rd(logic [2:0] idx, logic [31:0] exp, string tag);
        bus_addr = idx;
        push(0, exp, tag);
        settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R1 reset values
        rd(3'd0, 32'h0, "R1 ram");
        rd(3'd1, 32'h0, "R1 cart");
        rd(3'd2, 32'h7F, "R1 rlen");
        rd(3'd3, 32'h7F, "R1 wlen");
        rd(3'd4, 32'h0, "R1 stat");
        push(1, 32'd0, "R1 irq"); settle();

        // R3 address bit trimming
        wr(3'd0, 32'hFF12_3457, 4'hF);
        rd(3'd0, 32'h0012_3456, "R3 ram keep");
        wr(3'd1, 32'h1000_0001, 4'hF);
        rd(3'd1, 32'h1000_0000, "R3 cart bit0");

        // R2 lane merge
        wr(3'd1, 32'h0000_00A0, 4'b0001);
        rd(3'd1, 32'h1000_00A0, "R2 low lane");
        wr(3'd1, 32'h0000_0300, 4'b0000);
        rd(3'd1, 32'h1000_03A0, "R2 no lanes or");
        wr(3'd1, 32'h2200_0000, 4'b1000);
        rd(3'd1, 32'h2200_03A0, "R2 high lane");

        // R4 write-length launch
        wr(3'd3, 32'h0000_00FF, 4'hF);
        push(2, 32'd1, "R4 start");
        push(3, 32'h100, "R4 len");
        push(4, 32'd1, "R4 dir");
        push(5, 32'h0012_3456, "R4 ram addr");
        bus_addr = 3'd4; push(0, 32'h3, "R4 busy R10");
        settle();
        push(2, 32'd0, "R4 single pulse"); settle();

        // R6 writes while busy
        wr(3'd0, 32'h0, 4'hF);
        rd(3'd4, 32'h7, "R6 err R10");
        rd(3'd0, 32'h0012_3456, "R6 ram kept");
        wr(3'd2, 32'h5, 4'hF);
        push(2, 32'd0, "R6 no start"); settle();
        rd(3'd2, 32'h7F, "R6 rlen kept");

        // R8 completion
        done_pulse();
        rd(3'd4, 32'hC, "R8 stat");
        push(1, 32'd1, "R8 irq"); settle();
        rd(3'd3, 32'h7F, "R8 wlen fixed");

        // R9 clears
        wr(3'd4, 32'h2, 4'hF);
        rd(3'd4, 32'h4, "R9 clrint");
        push(1, 32'd0, "R9 irq low"); settle();
        wr(3'd4, 32'h1, 4'hF);
        rd(3'd4, 32'h0, "R9 reset ctl");

        // R5 read-length launch
        wr(3'd2, 32'h0000_000F, 4'hF);
        push(2, 32'd1, "R5 start");
        push(3, 32'h10, "R5 len");
        push(4, 32'd0, "R5 dir");
        settle();
        done_pulse();
        rd(3'd2, 32'h7F, "R8 rlen fixed");
        wr(3'd4, 32'h2, 4'hF);

        // R12 done collides with clear-interrupt
        wr(3'd2, 32'h0000_0003, 4'hF);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h2; bus_be = 4'hF;
        xfer_done = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; xfer_done = 1'b0;
        rd(3'd4, 32'h8, "R12 intr kept");
        push(1, 32'd1, "R12 irq"); settle();
        wr(3'd4, 32'h2, 4'hF);

        // R9 abort then R11 stray done
        wr(3'd3, 32'h0000_003F, 4'hF);
        wr(3'd4, 32'h1, 4'hF);
        rd(3'd4, 32'h0, "R9 abort");
        done_pulse();
        rd(3'd4, 32'h0, "R11 stat");
        push(1, 32'd0, "R11 irq"); settle();
        rd(3'd3, 32'h3F, "R11 wlen kept");

        // R7 all-ones RAM address
        wr(3'd0, 32'hFFFF_FFFF, 4'hF);
        rd(3'd0, 32'h00FF_FFFE, "R7 ram full");
        wr(3'd3, 32'h0000_0005, 4'hF);
        push(2, 32'd0, "R7 no start");
        push(1, 32'd1, "R7 irq");
        bus_addr = 3'd4; push(0, 32'h8, "R7 stat");
        settle();
        rd(3'd3, 32'h5, "R7 wlen stored");

        // R10 unmapped index
        rd(3'd6, 32'h0, "R10 unmapped");

        settle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule